// File: doc/BRIEF.md
# Capture and PWM Reload Timer

An up-counting timer with a power-of-two prescaler, a reload register and a compare register. In PWM mode the count runs from 1 up to the reload value and then starts again at 1. The output level follows the comparison of the count against the compare register. A dual PWM variant also drives the inverse waveform on the pin that serves as the timer input in other modes, and it raises an output enable for that pin.

In capture mode the timer keeps counting in the same way. When a qualifying edge arrives on the synchronized input pin, the count is copied into the compare register. The counter does not stop and does not restart. Every reload and every capture raises a one-cycle interrupt pulse. A sticky cause flag tells software which of the two events raised it.

Software uses a simple write port and a combinational read port to reach four registers:

| Select | Register | Contents |
|---|---|---|
| 0 | Control | bit0 enable, bits 2:1 mode, bit3 polarity, bits 6:4 prescale select. Reads return the cause flag in bit7. |
| 1 | Count | The running count. A write sets it. |
| 2 | Reload | The reload value. |
| 3 | Compare | The compare value, which is also where captures land. |

Top module: `cap_pwm_timer`

## Requirements
- R1: On each prescaled tick the count rises by one. A tick at which the count equals the reload value loads 1 into the count instead, and the interrupt output is high for exactly the following cycle.
- R2: Prescale select s (0..7) gives one tick every 2^s clocks. The prescaler restarts from zero while the timer is disabled, so the first tick after enabling comes 2^s cycles later.
- R3: With mode bit 2 set (mode 2 or 3) and the timer enabled, a qualifying input edge does three things. It copies the count held before that edge into the compare register. It pulses the interrupt. It leaves the counting undisturbed. Polarity 0 selects rising edges and polarity 1 selects falling edges.
- R4: The cause flag (control read bit7, also a port) is set by a capture and cleared by a reload. When both happen in the same cycle, it reads as set.
- R5: The input passes through two synchronizer flops and an edge register. A pin change that settles before clock edge k is acted on at edge k+2.
- R6: In PWM modes (0 and 1) while enabled, the output is (count > compare) with polarity 0, and (count <= compare) with polarity 1.
- R7: In mode 1 the complementary output enable is high and the complementary output is the inverse of the PWM output. In every other mode the enable and the complementary output are low. Input edges have no effect outside capture modes.
- R8: While disabled, or in a capture mode, the PWM output rests at its inactive level, which equals the polarity bit. While disabled, the count holds.
- R9: A count write takes effect at the next edge and overrides that cycle's tick. A count above the reload value counts up through wrap-around to the reload value, so the first period runs long, and later periods are full length.
- R10: Register reads return the stored values. A capture takes priority over a same-cycle write to the compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | CNT_W | Read data (combinational) |
| tin_i | input | 1 | Asynchronous timer input pin |
| pwm_o | output | 1 | PWM output |
| pwm_n_o | output | 1 | Complementary PWM output |
| pwm_n_oe | output | 1 | Enable for the complementary output pin |
| irq_o | output | 1 | One-cycle interrupt pulse |
| cap_flag_o | output | 1 | Interrupt cause flag (1 = capture) |

## Verification
The bench builds the timer with an 8-bit counter and the default 3-bit prescale select. With an 8-bit counter, a count written above the reload value wraps through 0xFF in a few hundred cycles, so the long first period can be observed. Small reload values let reloads and input edges land in the same cycle, which tests the cause-flag priority. The slowest division, 128, still fits in a short run.

// File: rtl/tmr_pkg.sv
// Shared definitions for the capture/PWM timer.
// Assumes the control register fits in the low 8 bits of the data path.
package tmr_pkg;

    localparam int CTRL_W = 7;

    typedef enum logic [1:0] {
        MODE_PWM      = 2'b00,
        MODE_PWM_DUAL = 2'b01,
        MODE_CAP      = 2'b10,
        MODE_CAP_ALT  = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_CMP    = 2'd3
    } tmr_sel_e;

    typedef struct packed {
        logic [2:0] psel;
        logic       pol;
        tmr_mode_e  mode;
        logic       en;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
// Power-of-two clock divider producing a one-cycle tick.
// Divides by 2^psel; the internal counter is held at zero while disabled,
// so the first tick after enabling arrives 2^psel cycles later.
module tmr_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [PS_W-1:0] psel,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Mask of the low psel bits that must all be ones for a tick.
    always_comb begin
        mask = ~({DIV_W{1'b1}} << psel);
    end

    assign tick = en && ((div_q & mask) == mask);

    // Free-running divider, cleared while the timer is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psel != '0) |=> (!tick || psel != $past(psel))) else $error("tick spacing"); // R2

endmodule

// File: rtl/tmr_edge_sync.sv
// Synchronizes the asynchronous timer input and flags the selected edge.
// Assumes STAGES >= 2; edge_o is a single-cycle pulse.
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic falling,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Synchronizer chain, one flop per stage.
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign edge_o = falling ? (last_q && !sync_q[STAGES-1])
                            : (!last_q && sync_q[STAGES-1]);

endmodule

// File: rtl/tmr_core.sv
// Count, reload and compare registers with interrupt and cause flag.
// The count restarts at 1 after matching reload; captures copy the
// pre-edge count into the compare register and win over software writes.
module tmr_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             cap_evt,
    input  logic             cnt_wr,
    input  logic             rel_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cmp,
    output logic             irq,
    output logic             cap_flag
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic rel_evt;

    assign rel_evt = tick && (cnt == reload);

    // Counter: software load first, then reload restart, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= CNT_ONE;
        else if (cnt_wr)  cnt <= wdata;
        else if (rel_evt) cnt <= CNT_ONE;
        else if (tick)    cnt <= cnt + 1'b1;
    end

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n)      reload <= '1;
        else if (rel_wr) reload <= wdata;
    end

    // Compare register, also the capture destination.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmp <= '0;
        else if (cap_evt) cmp <= cnt;
        else if (cmp_wr)  cmp <= wdata;
    end

    // Interrupt pulse and sticky cause flag (capture wins a tie).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            cap_flag <= 1'b0;
        end else begin
            irq <= cap_evt || rel_evt;
            if (cap_evt)      cap_flag <= 1'b1;
            else if (rel_evt) cap_flag <= 1'b0;
        end
    end

    AST_RELOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == reload && !cnt_wr) |=> (cnt == CNT_ONE && irq)) else $error("reload restart"); // R1
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(cnt)) else $error("count moved while disabled"); // R8
    AST_CAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cmp == $past(cnt))) else $error("capture value"); // R3
    AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_flag && irq)) else $error("capture flag"); // R4
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_evt && !rel_evt) |=> !irq) else $error("spurious irq"); // R1

endmodule

// File: rtl/tmr_pwm_out.sv
// Drives the PWM output and the complementary pin from the count and
// compare registers. Rests at the polarity level when idle or capturing.
module tmr_pwm_out #(
    parameter int CNT_W = 16
) (
    input  logic             en,
    input  tmr_pkg::tmr_mode_e mode,
    input  logic             pol,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             pwm,
    output logic             pwm_n,
    output logic             pwm_n_oe
);
    import tmr_pkg::*;

    logic active;

    // PWM level: count above compare, inverted by polarity.
    always_comb begin
        active   = en && (mode == MODE_PWM || mode == MODE_PWM_DUAL);
        pwm      = active ? ((cnt > cmp) ^ pol) : pol;
        pwm_n_oe = (mode == MODE_PWM_DUAL);
        pwm_n    = pwm_n_oe ? !pwm : 1'b0;
    end

endmodule

// File: rtl/cap_pwm_timer.sv
// Top level: control register, register read mux and submodule wiring.
// Assumes CNT_W >= 8 so the control register and flag fit the data path.
module cap_pwm_timer #(
    parameter int CNT_W   = 16,
    parameter int PS_W    = 3,
    parameter int STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic             tin_i,
    output logic             pwm_o,
    output logic             pwm_n_o,
    output logic             pwm_n_oe,
    output logic             irq_o,
    output logic             cap_flag_o
);
    import tmr_pkg::*;

    tmr_ctrl_t        ctrl;
    logic             tick;
    logic             edge_seen;
    logic             cap_evt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cmp;
    logic             unused_wr_hi;

    assign unused_wr_hi = ^wr_data[CNT_W-1:CTRL_W];

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctrl <= '0;
        else if (wr_en && wr_sel == SEL_CTRL)    ctrl <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    tmr_prescaler #(.PS_W(PS_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl.en),
        .psel  (ctrl.psel[PS_W-1:0]),
        .tick  (tick)
    );

    tmr_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (tin_i),
        .falling (ctrl.pol),
        .edge_o  (edge_seen)
    );

    assign cap_evt = edge_seen && ctrl.en && ctrl.mode[1];

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl.en),
        .tick     (tick),
        .cap_evt  (cap_evt),
        .cnt_wr   (wr_en && wr_sel == SEL_COUNT),
        .rel_wr   (wr_en && wr_sel == SEL_RELOAD),
        .cmp_wr   (wr_en && wr_sel == SEL_CMP),
        .wdata    (wr_data),
        .cnt      (cnt),
        .reload   (reload),
        .cmp      (cmp),
        .irq      (irq_o),
        .cap_flag (cap_flag_o)
    );

    tmr_pwm_out #(.CNT_W(CNT_W)) u_pwm (
        .en       (ctrl.en),
        .mode     (ctrl.mode),
        .pol      (ctrl.pol),
        .cnt      (cnt),
        .cmp      (cmp),
        .pwm      (pwm_o),
        .pwm_n    (pwm_n_o),
        .pwm_n_oe (pwm_n_oe)
    );

    // Combinational register read mux.
    always_comb begin
        unique case (rd_sel)
            SEL_CTRL:   rd_data = CNT_W'({cap_flag_o, ctrl});
            SEL_COUNT:  rd_data = cnt;
            SEL_RELOAD: rd_data = reload;
            default:    rd_data = cmp;
        endcase
    end

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en || ctrl.mode[1]) |-> (pwm_o == ctrl.pol)) else $error("idle level"); // R8
    AST_DUAL_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_n_oe |-> !pwm_n_o) else $error("complement pin driven"); // R7

endmodule

// File: tb/cap_pwm_timer_test.sv
// Behavioural reference model compared against the timer every cycle.
module cap_pwm_timer_test;
    localparam int CNT_W = 8;
    localparam int MAXV  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [1:0]       rd_sel = '0;
    logic [CNT_W-1:0] rd_data;
    logic             tin_i = 1'b0;
    logic             pwm_o, pwm_n_o, pwm_n_oe, irq_o, cap_flag_o;

    int vectors = 0;
    int errors  = 0;
    string phase = "R1";
    bit armed = 0;
    bit done = 0;

    // model state
    int m_ctrl, m_cnt, m_rel, m_cmp, m_ps, m_irq, m_flag, m_s1, m_s2, m_prev;

    cap_pwm_timer #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .tin_i(tin_i),
        .pwm_o(pwm_o), .pwm_n_o(pwm_n_o), .pwm_n_oe(pwm_n_oe),
        .irq_o(irq_o), .cap_flag_o(cap_flag_o)
    );

    always #10 clk = ~clk;

    // Reference model: next state from the current state and inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_cnt = 1; m_rel = MAXV; m_cmp = 0; m_ps = 0;
            m_irq = 0; m_flag = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            int en, mode, pol, psel, mask, tick, cap, rel;
            int n_cnt, n_cmp;
            en = m_ctrl & 1; mode = (m_ctrl >> 1) & 3;
            pol = (m_ctrl >> 3) & 1; psel = (m_ctrl >> 4) & 7;
            mask = (1 << psel) - 1;
            tick = en && ((m_ps & mask) == mask);
            cap = en && (mode >= 2) &&
                  (pol ? (m_prev && !m_s2) : (!m_prev && m_s2));
            rel = tick && (m_cnt == m_rel);
            n_cnt = m_cnt;
            if (wr_en && wr_sel == 1) n_cnt = int'(wr_data);
            else if (rel) n_cnt = 1;
            else if (tick) n_cnt = (m_cnt + 1) & MAXV;
            n_cmp = m_cmp;
            if (cap) n_cmp = m_cnt;
            else if (wr_en && wr_sel == 3) n_cmp = int'(wr_data);
            if (wr_en && wr_sel == 2) m_rel = int'(wr_data);
            m_irq = (cap || rel) ? 1 : 0;
            if (cap) m_flag = 1; else if (rel) m_flag = 0;
            m_ps = en ? ((m_ps + 1) & 127) : 0;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = tin_i;
            m_cnt = n_cnt; m_cmp = n_cmp;
            if (wr_en && wr_sel == 0) m_ctrl = int'(wr_data) & 127;
        end
        armed = 1;
    end

    task automatic check(string what, string req, int act, int exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s, phase %s) actual=%0h expected=%0h t=%0t",
                     what, req, phase, act, exp, $time);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            int en, mode, pol, e_pwm, e_oe, e_rd;
            en = m_ctrl & 1; mode = (m_ctrl >> 1) & 3; pol = (m_ctrl >> 3) & 1;
            e_pwm = (en && mode < 2) ? (((m_cnt > m_cmp) ? 1 : 0) ^ pol) : pol;
            e_oe  = (mode == 1) ? 1 : 0;
            case (rd_sel)
                2'd0: e_rd = m_ctrl | (m_flag << 7);
                2'd1: e_rd = m_cnt;
                2'd2: e_rd = m_rel;
                default: e_rd = m_cmp;
            endcase
            vectors++;
            check("pwm_o", "R6", int'(pwm_o), e_pwm);
            check("pwm_n_oe", "R7", int'(pwm_n_oe), e_oe);
            check("pwm_n_o", "R7", int'(pwm_n_o), e_oe ? 1 - e_pwm : 0);
            check("irq_o", "R1", int'(irq_o), m_irq);
            check("cap_flag_o", "R4", int'(cap_flag_o), m_flag);
            check("rd_data", "R10", int'(rd_data), e_rd);
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk); #2;
            rd_sel = rd_sel + 1'b1;
        end
    endtask

    task automatic wr(int sel, int data);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = CNT_W'(data);
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog (all) actual=running expected=finished");
        finish_run();
    end

    initial begin
        phase = "R10";                 // reset state
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        step(4);
        phase = "R1";                  // reload restart, pol0 PWM (R6)
        wr(2, 5); wr(3, 2); wr(0, 8'h01);
        step(30);
        phase = "R6";                  // inverted polarity
        wr(0, 8'h09);
        step(20);
        phase = "R7";                  // dual mode, edges ignored
        wr(0, 8'h03);
        for (int i = 0; i < 8; i++) begin tin_i = ~tin_i; step(3); end
        phase = "R2";                  // prescale 4 then 128
        wr(0, 8'h23);
        step(40);
        wr(0, 8'h71); wr(2, 3);
        step(1100);
        phase = "R8";                  // disable: freeze and idle level
        wr(0, 8'h08);
        step(15);
        wr(0, 8'h00);
        step(5);
        phase = "R3";                  // capture rising, then falling
        tin_i = 1'b0;
        wr(2, 40); wr(0, 8'h05);
        step(7); tin_i = 1'b1; step(9); tin_i = 1'b0; step(11);
        phase = "R5";                  // falling-edge capture latency
        wr(0, 8'h0D);
        step(5); tin_i = 1'b1; step(6); tin_i = 1'b0; step(8);
        phase = "R4";                  // capture/reload collisions
        wr(2, 6); wr(0, 8'h05);
        for (int i = 0; i < 40; i++) begin tin_i = ~tin_i; step(3); end
        phase = "R10";                 // capture vs same-cycle compare write
        for (int i = 0; i < 6; i++) begin
            tin_i = ~tin_i; step(2); wr(3, 8'h11 + i); step(1);
        end
        phase = "R9";                  // long first period through wrap
        wr(0, 8'h01); wr(2, 5); wr(3, 3); wr(1, 250);
        step(40);
        wr(1, 9); step(300);
        finish_run();
    end

endmodule